// File: doc/BRIEF.md
# Bank Precharge and Activate Timing Guard

This block sits in a memory controller beside the command scheduler for one SDRAM bank. It watches the commands issued to the bank: activate, read, read with auto precharge, and precharge. From these it produces two permits. One says whether a precharge may be issued in the current cycle. The other says whether a new activate may be issued. A registered violation flag pulses when the scheduler issues a precharge or an activate whose permit is low. The guard then still applies that command to its own timing, so its later permits follow what the device actually received.

The row-precharge time and the minimum row-active time are given in picoseconds. At elaboration each one is converted to clock cycles by ceiling division by the clock period. A read keeps the bank's data path busy for half the burst length in clock cycles, shifted by the CAS latency. A precharge issued before that span ends cuts the data off early. A read with auto precharge starts its internal precharge at the same point an external precharge would have to use to leave the burst whole: half a burst after the read. If the minimum row-active time has not yet elapsed at that point, the internal precharge waits for it.

A four-state machine holds the bank condition:
- `BK_IDLE`: the bank is precharged.
- `BK_OPEN`: a row is open.
- `BK_AUTOPRE`: a read with auto precharge was accepted and the internal precharge has not started yet.
- `BK_RECOVER`: the precharge recovery time is running.

The transitions are as follows:
- An activate in any state moves to `BK_OPEN`.
- A precharge in any state moves to `BK_RECOVER`.
- From `BK_OPEN`, a read with auto precharge moves to `BK_AUTOPRE`.
- `BK_AUTOPRE` fires to `BK_RECOVER` once the burst span and the row-active time have both elapsed.
- `BK_RECOVER` returns to `BK_IDLE` when the recovery count reaches zero.

Top module: `bank_timing_guard`

## Requirements
- R1: After reset, the bank is idle. `act_ok_o`=1, `pre_ok_o`=0, `viol_o`=0 and `dq_drive_o`=0.
- R2: With NRP = ceil(TRP_PS/TCK_PS), a precharge in cycle p keeps `act_ok_o` low in cycles p+1 to p+NRP-1 and raises it in cycle p+NRP.
- R3: With NRAS = ceil(TRAS_PS/TCK_PS), an activate in cycle a keeps `pre_ok_o` low until cycle a+NRAS and raises it from then on while the bank is open. `pre_ok_o` is low in the idle, auto-precharge-wait and recovery states.
- R4: A read accepted in cycle r drives `dq_drive_o` high in cycles r+CAS_LAT to r+CAS_LAT+BURST_LEN/2-1. A precharge in cycle r+BURST_LEN/2, the earliest one that does not cut the burst, leaves this window whole.
- R5: A precharge in cycle p during an unfinished burst makes p+CAS_LAT-1 the last cycle with `dq_drive_o` high.
- R6: A read with auto precharge in cycle r, with the row-active time already met, raises `act_ok_o` first in cycle r+BURST_LEN/2+NRP.
- R7: A read with auto precharge issued before the row-active time has elapsed since the activate in cycle a delays the internal precharge to cycle a+NRAS. `act_ok_o` then rises first in cycle a+NRAS+NRP.
- R8: An activate with `act_ok_o` low, or a precharge with `pre_ok_o` low, raises `viol_o` for exactly the next cycle. The command is still applied, and the timing restarts from it.
- R9: In a cycle where a read strobe is asserted, `pre_ok_o` is low. A precharge issued together with a read is flagged, is applied as a precharge, and its read produces no `dq_drive_o` window.
- R10: Read strobes in any state other than open are ignored and produce no `dq_drive_o` window.
- R11: A second read accepted during a burst restarts the window. `dq_drive_o` stays high through r2+CAS_LAT+BURST_LEN/2-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all commands are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| act_i | input | 1 | Activate issued to this bank this cycle (highest priority) |
| pre_i | input | 1 | Precharge issued to this bank this cycle |
| rd_i | input | 1 | Read issued to this bank this cycle |
| rda_i | input | 1 | Read with auto precharge issued to this bank this cycle |
| pre_ok_o | output | 1 | A precharge may be issued this cycle |
| act_ok_o | output | 1 | An activate may be issued this cycle |
| viol_o | output | 1 | The previous cycle's activate or precharge broke its permit |
| dq_drive_o | output | 1 | Read data from this bank occupies the data path this cycle |

## Verification
The timing parameters are chosen so that neither picosecond value divides evenly by the clock period. A floor conversion would then open each permit one cycle early, and the exact rise cycles of both permits tell the two conversions apart. Read patterns cover four cases: a lone read, a read cut early by a precharge, a read followed by a precharge exactly half a burst later, and two reads two cycles apart. Their `dq_drive_o` windows tell a truncating precharge from a non-truncating one and a restart from a plain continuation. Auto-precharge reads are issued both after and before the row-active time has run out, which separates a start point fixed to the burst from one that waits for the row-active time. Illegal activates and precharges, a precharge paired with a read, and reads in the wrong state show that violations pulse once and that the flagged command still moves the timing.

// File: rtl/bank_guard_pkg.sv
`timescale 1ns/1ps
package bank_guard_pkg;

    // Bank condition tracked by the guard.
    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPEN    = 2'd1,
        BK_AUTOPRE = 2'd2,
        BK_RECOVER = 2'd3
    } bank_state_e;

    // Analog time to whole clock cycles, rounded up.
    function automatic int ceil_cycles(input int span_ps, input int period_ps);
        return (span_ps + period_ps - 1) / period_ps;
    endfunction

endpackage

// File: rtl/bg_count.sv
`timescale 1ns/1ps
// Loadable down counter that stops at zero; reports when it has run out.
module bg_count #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

    // R3
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/bg_beat_pipe.sv
`timescale 1ns/1ps
// Delays the per-cycle "burst beat live" flag by the CAS latency.
module bg_beat_pipe #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (DEPTH == 1) begin : g_one
            logic stage;
            always_ff @(posedge clk) begin
                if (!rst_n) stage <= 1'b0;
                else        stage <= d;
            end
            assign q = stage;
        end else begin : g_chain
            logic [DEPTH-1:0] stage;
            always_ff @(posedge clk) begin
                if (!rst_n) stage <= '0;
                else        stage <= {stage[DEPTH-2:0], d};
            end
            assign q = stage[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/bg_fsm.sv
`timescale 1ns/1ps
// Bank condition machine: permits, counter loads and violation flag.
module bg_fsm
    import bank_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic pre_i,
    input  logic rd_i,
    input  logic rda_i,
    input  logic ras_done,
    input  logic rp_done,
    input  logic burst_done,
    output logic pre_ok,
    output logic act_ok,
    output logic viol,
    output logic ld_ras,
    output logic ld_rp,
    output logic ld_burst,
    output logic burst_go,
    output logic beat_live
);

    bank_state_e st;
    bank_state_e nxt;
    logic        rd_take;
    logic        auto_fire;
    logic        viol_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= BK_IDLE;
        else        st <= nxt;
    end

    // Registered violation flag: one cycle after the offending command.
    always_ff @(posedge clk) begin
        if (!rst_n) viol_q <= 1'b0;
        else        viol_q <= (act_i && !act_ok) || (pre_i && !pre_ok);
    end

    assign viol = viol_q;

    // Next-state selection; activate beats precharge beats everything else.
    always_comb begin
        nxt = st;
        if (act_i) begin
            nxt = BK_OPEN;
        end else if (pre_i) begin
            nxt = BK_RECOVER;
        end else begin
            unique case (st)
                BK_IDLE:    nxt = BK_IDLE;
                BK_OPEN:    if (rd_take && rda_i) nxt = BK_AUTOPRE;
                BK_AUTOPRE: if (auto_fire) nxt = BK_RECOVER;
                BK_RECOVER: if (rp_done) nxt = BK_IDLE;
                default:    nxt = BK_IDLE;
            endcase
        end
    end

    // Permits and counter controls.
    always_comb begin
        pre_ok    = 1'b0;
        act_ok    = 1'b0;
        rd_take   = 1'b0;
        auto_fire = 1'b0;
        unique case (st)
            BK_IDLE: begin
                act_ok = 1'b1;
            end
            BK_OPEN: begin
                pre_ok  = ras_done && !rd_i && !rda_i;
                rd_take = (rd_i || rda_i) && !pre_i && !act_i;
            end
            BK_AUTOPRE: begin
                auto_fire = burst_done && ras_done && !pre_i && !act_i;
            end
            BK_RECOVER: begin
                act_ok = rp_done;
            end
            default: begin
                act_ok = 1'b0;
            end
        endcase
        ld_ras    = act_i;
        ld_rp     = (pre_i && !act_i) || auto_fire;
        ld_burst  = rd_take || act_i || pre_i;
        burst_go  = rd_take;
        beat_live = rd_take || (!burst_done && !act_i && !pre_i);
    end

    // R2
    pre_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_i && !act_i) |=> (st == BK_RECOVER));

    // R8
    viol_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i && !act_ok) |=> viol);

    // R8
    viol_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_i && !pre_i) |=> !viol);

    // R7
    auto_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BK_AUTOPRE && !ras_done && !act_i && !pre_i) |=> (st == BK_AUTOPRE));

    // R6
    auto_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BK_AUTOPRE && burst_done && ras_done && !act_i && !pre_i)
            |=> (st == BK_RECOVER));

endmodule

// File: rtl/bank_timing_guard.sv
`timescale 1ns/1ps
// Per-bank precharge / activate timing guard.
module bank_timing_guard
    import bank_guard_pkg::*;
#(
    parameter int TCK_PS    = 2500,
    parameter int TRP_PS    = 15000,
    parameter int TRAS_PS   = 40000,
    parameter int CAS_LAT   = 3,
    parameter int BURST_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic pre_i,
    input  logic rd_i,
    input  logic rda_i,
    output logic pre_ok_o,
    output logic act_ok_o,
    output logic viol_o,
    output logic dq_drive_o
);

    localparam int TRP_CYC  = ceil_cycles(TRP_PS, TCK_PS);
    localparam int TRAS_CYC = ceil_cycles(TRAS_PS, TCK_PS);
    localparam int HALF_BL  = BURST_LEN / 2;
    localparam int RP_W     = $clog2(TRP_CYC + 1);
    localparam int RAS_W    = $clog2(TRAS_CYC + 1);
    localparam int BUR_W    = $clog2(HALF_BL + 1);
    localparam logic [RP_W-1:0]  RP_LOAD  = RP_W'(TRP_CYC - 1);
    localparam logic [RAS_W-1:0] RAS_LOAD = RAS_W'(TRAS_CYC - 1);
    localparam logic [BUR_W-1:0] BUR_LOAD = BUR_W'(HALF_BL - 1);

    logic ras_done;
    logic rp_done;
    logic burst_done;
    logic ld_ras;
    logic ld_rp;
    logic ld_burst;
    logic burst_go;
    logic beat_live;
    logic [BUR_W-1:0] burst_val;

    bg_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_i      (act_i),
        .pre_i      (pre_i),
        .rd_i       (rd_i),
        .rda_i      (rda_i),
        .ras_done   (ras_done),
        .rp_done    (rp_done),
        .burst_done (burst_done),
        .pre_ok     (pre_ok_o),
        .act_ok     (act_ok_o),
        .viol       (viol_o),
        .ld_ras     (ld_ras),
        .ld_rp      (ld_rp),
        .ld_burst   (ld_burst),
        .burst_go   (burst_go),
        .beat_live  (beat_live)
    );

    // Row-active time since the last activate.
    bg_count #(.W(RAS_W)) u_ras (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_ras),
        .load_val (RAS_LOAD),
        .done     (ras_done)
    );

    // Precharge recovery time.
    bg_count #(.W(RP_W)) u_rp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_rp),
        .load_val (RP_LOAD),
        .done     (rp_done)
    );

    // Remaining command-side beats of the current read burst.
    assign burst_val = burst_go ? BUR_LOAD : '0;

    bg_count #(.W(BUR_W)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_burst),
        .load_val (burst_val),
        .done     (burst_done)
    );

    bg_beat_pipe #(.DEPTH(CAS_LAT)) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (beat_live),
        .q     (dq_drive_o)
    );

    // R5
    cut_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_i && !act_i) |=> !beat_live);

    // R1
    idle_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_ok_o) |-> !act_ok_o);

endmodule

// File: tb/bank_timing_guard_bench.sv
`timescale 1ns/1ps
module bank_timing_guard_bench;

    // NRP = ceil(15000/4000) = 4, NRAS = ceil(42000/4000) = 11, BL/2 = 4, CL = 3
    localparam int NOP = 0, ACT = 1, PRE = 2, RD = 3, RDA = 4, PRERD = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic act_i = 1'b0, pre_i = 1'b0, rd_i = 1'b0, rda_i = 1'b0;
    logic pre_ok_o, act_ok_o, viol_o, dq_drive_o;
    logic s_pre, s_act, s_viol, s_dq;
    int   checks = 0;
    int   errs = 0;

    always #4 clk = ~clk;

    bank_timing_guard #(
        .TCK_PS(4000), .TRP_PS(15000), .TRAS_PS(42000), .CAS_LAT(3), .BURST_LEN(8)
    ) u_bank_timing_guard (
        .clk(clk), .rst_n(rst_n), .act_i(act_i), .pre_i(pre_i), .rd_i(rd_i),
        .rda_i(rda_i), .pre_ok_o(pre_ok_o), .act_ok_o(act_ok_o), .viol_o(viol_o),
        .dq_drive_o(dq_drive_o)
    );

    // {cmd[2:0], pre_ok, act_ok, viol, dq} per cycle, starting right after reset
    localparam int ROWS = 19;
    localparam logic [6:0] VEC [0:ROWS-1] = '{
        7'b000_0100, 7'b001_0100, 7'b000_0000, 7'b011_0000, 7'b000_0000,
        7'b000_0000, 7'b000_0001, 7'b000_0001, 7'b000_0001, 7'b000_0001,
        7'b000_0000, 7'b000_0000, 7'b000_1000, 7'b010_1000, 7'b000_0000,
        7'b000_0000, 7'b001_0000, 7'b000_0010, 7'b000_0000
    };

    task automatic drive(input int code);
        @(negedge clk);
        act_i = (code == ACT);
        pre_i = (code == PRE) || (code == PRERD);
        rd_i  = (code == RD) || (code == PRERD);
        rda_i = (code == RDA);
        #1;
        s_pre = pre_ok_o; s_act = act_ok_o; s_viol = viol_o; s_dq = dq_drive_o;
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) drive(NOP);
    endtask

    task automatic chk(input logic got, input logic exp, input string tag, input string what);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s %s: got %0b expected %0b", tag, what, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; act_i = 0; pre_i = 0; rd_i = 0; rda_i = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        do_reset();
        // Table walk: R2 act_ok, R3 pre_ok, R8 viol, R4 dq window
        for (int i = 0; i < ROWS; i++) begin
            drive(int'(VEC[i][6:4]));
            chk(s_pre, VEC[i][3], "R3", "pre_ok");
            chk(s_act, VEC[i][2], "R2", "act_ok");
            chk(s_viol, VEC[i][1], "R8", "viol");
            chk(s_dq, VEC[i][0], "R4", "dq_drive");
        end
        // R8: illegal activate at row 16 still restarts the row-active count
        nop(8);
        chk(s_pre, 1'b0, "R8", "pre_ok one before tracked tRAS");
        drive(NOP);
        chk(s_pre, 1'b1, "R8", "pre_ok at tracked tRAS");

        // R1: reset mid-operation
        drive(ACT); nop(3);
        do_reset();
        drive(NOP);
        chk(s_act, 1'b1, "R1", "act_ok after reset");
        chk(s_pre, 1'b0, "R1", "pre_ok after reset");
        chk(s_viol, 1'b0, "R1", "viol after reset");
        chk(s_dq, 1'b0, "R1", "dq after reset");

        // R8 / R2: precharge in idle flagged once, recovery tracked (NRP=4)
        do_reset();
        drive(PRE);
        drive(NOP); chk(s_viol, 1'b1, "R8", "viol after idle precharge");
        chk(s_act, 1'b0, "R2", "act_ok p+1");
        drive(NOP); chk(s_viol, 1'b0, "R8", "viol single pulse");
        drive(NOP); chk(s_act, 1'b0, "R2", "act_ok p+3");
        drive(NOP); chk(s_act, 1'b1, "R2", "act_ok p+4");

        // R3 / R6: auto precharge after tRAS met
        do_reset();
        drive(ACT); nop(9);
        drive(NOP); chk(s_pre, 1'b0, "R3", "pre_ok a+10");
        drive(NOP); chk(s_pre, 1'b1, "R3", "pre_ok a+11");
        drive(RDA);
        drive(NOP); chk(s_pre, 1'b0, "R3", "pre_ok in auto wait");
        nop(5);
        drive(NOP); chk(s_act, 1'b0, "R6", "act_ok r+7");
        drive(NOP); chk(s_act, 1'b1, "R6", "act_ok r+8");

        // R7: auto precharge before tRAS met
        do_reset();
        drive(ACT); drive(RDA); nop(12);
        drive(NOP); chk(s_act, 1'b0, "R7", "act_ok a+14");
        drive(NOP); chk(s_act, 1'b1, "R7", "act_ok a+15");

        // R5: truncating precharge two cycles after read
        do_reset();
        drive(ACT); nop(10);
        drive(RD); drive(NOP);
        drive(PRE); chk(s_pre, 1'b1, "R5", "pre_ok at cut");
        drive(NOP); chk(s_dq, 1'b1, "R5", "dq r+3"); chk(s_viol, 1'b0, "R5", "viol legal cut");
        drive(NOP); chk(s_dq, 1'b1, "R5", "dq r+4");
        drive(NOP); chk(s_dq, 1'b0, "R5", "dq r+5");

        // R4: precharge at r+BL/2 does not cut the window
        do_reset();
        drive(ACT); nop(10);
        drive(RD); drive(NOP);
        drive(NOP); chk(s_dq, 1'b0, "R4", "dq r+2");
        drive(NOP); chk(s_dq, 1'b1, "R4", "dq r+3");
        drive(PRE); chk(s_dq, 1'b1, "R4", "dq r+4");
        drive(NOP);
        drive(NOP); chk(s_dq, 1'b1, "R4", "dq r+6");
        drive(NOP); chk(s_dq, 1'b0, "R4", "dq r+7");

        // R11: second read restarts the window
        do_reset();
        drive(ACT); nop(10);
        drive(RD); drive(NOP); drive(RD); nop(5);
        drive(NOP); chk(s_dq, 1'b1, "R11", "dq r+8");
        drive(NOP); chk(s_dq, 1'b0, "R11", "dq r+9");

        // R9: precharge together with read
        do_reset();
        drive(ACT); nop(10);
        drive(PRERD); chk(s_pre, 1'b0, "R9", "pre_ok with read strobe");
        drive(NOP); chk(s_viol, 1'b1, "R9", "viol after paired precharge");
        drive(NOP);
        drive(NOP); chk(s_dq, 1'b0, "R9", "dq of discarded read");
        drive(NOP); chk(s_act, 1'b1, "R9", "act_ok after tracked precharge");

        // R10: read in idle ignored
        do_reset();
        drive(RD); nop(2);
        drive(NOP); chk(s_dq, 1'b0, "R10", "dq c+3");
        drive(NOP);
        drive(NOP); chk(s_dq, 1'b0, "R10", "dq c+5");
        drive(NOP);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule